// File: doc/BRIEF.md
# NAND Page Array Controller

This block stands in for a small-page NAND storage array inside a chip. The array lives in on-chip RAM. Every page is a data region followed by a spare region one thirty-second of its size. A command decoder next to the block presents one command per cycle, together with a page number, a column and an optional start offset.

The block supports three operations. Reads stream bytes one per `rd_en_i` pulse, starting at the chosen column. Program collects incoming bytes in a page buffer and then merges them into the array with a bitwise AND, so it can only clear bits. Erase returns a whole block of pages, spare bytes included, to 0xFF.

Program and erase run as a busy period, one array byte per cycle followed by a fixed tail. The write-protect pin gates both operations. A spare-disable pin lets a read stop at the end of the data region.

Top module: `nand_page_array`

## Requirements
- R1: After reset `busy_o` and `rd_valid_o` are low, and every byte of every page, data and spare, reads as 0xFF.
- R2: A load (`cmd_op_i`=1) of an in-range page sets the stream to begin at column plus stored offset. With `spare_off_i` low, `rd_valid_o` stays high for exactly ROW minus that start byte reads, where ROW is page plus spare bytes. Each accepted `rd_en_i` advances one byte. `rd_data_o` shows the byte at the current position, and `rd_valid_o` goes low after the last byte.
- R3: With `spare_off_i` high at load time, the stream ends at the last data byte, so it gives PAGE_BYTES minus the start byte reads.
- R4: An offset command (`cmd_op_i`=0) stores `start_off_i`. The next load or program-begin (`cmd_op_i`=2) adds it to the column and clears it, so a later command starts at the bare column.
- R5: A program commit (`cmd_op_i`=3) after a program-begin replaces each addressed byte with the old value ANDed with the collected byte. Collected byte i goes to start+i.
- R6: At most ROW bytes are collected after program-begin, and further `din_valid_i` bytes are dropped. Bytes whose position would pass the end of the page's spare region are not written.
- R7: With `wp_n_i` low, a commit or an erase (`cmd_op_i`=4) raises no busy period and leaves the array unchanged.
- R8: A commit or erase whose page, or aligned block, is at or beyond NUM_PAGES raises no busy period and changes nothing.
- R9: Erase aligns the page down to a multiple of 2^ERASE_SHIFT and sets every data and spare byte of that block to 0xFF. Other blocks keep their contents.
- R10: A busy period lasts W + BUSY_CYCLES cycles. W is the number of bytes written: the programmed count or 2^ERASE_SHIFT*ROW. While busy, commands, data bytes and read advances are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | 0 offset, 1 load, 2 program-begin, 3 program-commit, 4 erase |
| page_i | input | PAGE_AW | Page number |
| col_i | input | COL_W | Column within the page row |
| start_off_i | input | COL_W | Start offset stored by the offset command |
| din_valid_i | input | 1 | Program data byte present |
| din_i | input | 8 | Program data byte |
| rd_en_i | input | 1 | Advance the read stream by one byte |
| wp_n_i | input | 1 | High allows program and erase |
| spare_off_i | input | 1 | High hides the spare region from reads |
| rd_data_o | output | 8 | Byte at the current read position, 0 when no stream |
| rd_valid_o | output | 1 | Read stream has bytes left |
| busy_o | output | 1 | Program or erase in progress |

## Verification
A command seen at one clock edge is reflected in `rd_valid_o`, `rd_data_o` and `busy_o` right after that edge. The bench therefore drives inputs on the falling edge and samples outputs on the next falling edge. A read advance likewise shows the next byte one edge later, and the bench walks each stream one falling edge per byte. Busy periods are measured by counting falling-edge samples with `busy_o` high, starting just after the commit or erase edge, and the count is compared with the byte count plus the tail length. Array contents are checked only after busy has dropped, by streaming the pages back out.

// File: rtl/nand_pa_pkg.sv
package nand_pa_pkg;

    typedef enum logic [2:0] {
        OP_OFFSET     = 3'd0,
        OP_LOAD       = 3'd1,
        OP_PROG_BEGIN = 3'd2,
        OP_PROG_GO    = 3'd3,
        OP_ERASE      = 3'd4
    } nand_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WORK,
        SQ_HOLD
    } seq_state_e;

    function automatic int spare_bytes(input int page_bytes);
        return page_bytes >> 5;
    endfunction

endpackage

// File: rtl/nand_pa_array.sv
module nand_pa_array #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          erase,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= erase ? 8'hFF : (mem[waddr] & wdata);
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nand_pa_pgbuf.sv
module nand_pa_pgbuf #(
    parameter int ROW = 264,
    parameter int IW  = 9,
    parameter int BCW = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           wr,
    input  logic [7:0]     din,
    input  logic [IW-1:0]  ridx,
    output logic [7:0]     rdata,
    output logic [BCW-1:0] count
);
    logic [7:0] store [ROW];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (wr && int'(count) < ROW) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clear && wr && int'(count) < ROW) store[count[IW-1:0]] <= din;
    end

    assign rdata = store[ridx];
endmodule

// File: rtl/nand_pa_seq.sv
module nand_pa_seq
    import nand_pa_pkg::*;
#(
    parameter int AW   = 12,
    parameter int CW   = 11,
    parameter int HOLD = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_erase,
    input  logic [AW-1:0] go_base,
    input  logic [CW-1:0] go_cnt,
    output logic          busy_o,
    output logic          we_o,
    output logic          erase_o,
    output logic [AW-1:0] waddr_o,
    output logic [CW-1:0] idx_o
);
    localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;

    seq_state_e    state;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] base_q;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            hold_q  <= '0;
            idx_o   <= '0;
            erase_o <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: if (go) begin
                    base_q  <= go_base;
                    cnt_q   <= go_cnt;
                    erase_o <= go_erase;
                    idx_o   <= '0;
                    hold_q  <= HW'(HOLD - 1);
                    state   <= (go_cnt == '0) ? SQ_HOLD : SQ_WORK;
                end
                SQ_WORK: begin
                    idx_o <= idx_o + 1'b1;
                    if (idx_o == cnt_q - 1'b1) state <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    if (hold_q == '0) state <= SQ_IDLE;
                    else hold_q <= hold_q - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o  = (state != SQ_IDLE);
    assign we_o    = (state == SQ_WORK);
    assign waddr_o = base_q + AW'(idx_o);
endmodule

// File: rtl/nand_page_array.sv
module nand_page_array
    import nand_pa_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int NUM_PAGES   = 8,
    parameter int ERASE_SHIFT = 2,
    parameter int PAGE_AW     = 4,
    parameter int BUSY_CYCLES = 3,
    localparam int ROW_L      = PAGE_BYTES + (PAGE_BYTES >> 5),
    localparam int COL_W      = $clog2(ROW_L)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [PAGE_AW-1:0] page_i,
    input  logic [COL_W-1:0]   col_i,
    input  logic [COL_W-1:0]   start_off_i,
    input  logic               din_valid_i,
    input  logic [7:0]         din_i,
    input  logic               rd_en_i,
    input  logic               wp_n_i,
    input  logic               spare_off_i,
    output logic [7:0]         rd_data_o,
    output logic               rd_valid_o,
    output logic               busy_o
);
    localparam int SPARE   = spare_bytes(PAGE_BYTES);
    localparam int ROW     = PAGE_BYTES + SPARE;
    localparam int DEPTH   = NUM_PAGES * ROW;
    localparam int AW      = $clog2(DEPTH);
    localparam int SW      = COL_W + 1;
    localparam int BLK     = 1 << ERASE_SHIFT;
    localparam int ERASE_N = BLK * ROW;
    localparam int CW      = $clog2(ERASE_N + 1);
    localparam int BCW     = $clog2(ROW + 1);

    nand_op_e      op;
    logic          accept;
    logic [COL_W-1:0] off_q;
    logic [SW-1:0] start_now, limit, avail_now, prog_n;
    logic [AW-1:0] page_base;
    logic          page_ok;
    int            page_int, blk_int;

    logic [AW-1:0] rd_ptr;
    logic [SW-1:0] rd_left;
    logic          collecting_q, prog_ok_q;
    logic [AW-1:0] prog_base_q;
    logic [SW-1:0] prog_avail_q;

    logic          go, go_erase;
    logic [AW-1:0] go_base;
    logic [CW-1:0] go_cnt;
    logic          busy, we, erase;
    logic [AW-1:0] waddr;
    logic [CW-1:0] idx;
    logic [7:0]    buf_rdata, arr_rdata;
    logic [BCW-1:0] buf_count;

    always_comb begin
        op        = nand_op_e'(cmd_op_i);
        accept    = cmd_valid_i && !busy;
        page_int  = int'(page_i);
        blk_int   = (page_int >> ERASE_SHIFT) << ERASE_SHIFT;
        page_ok   = page_int < NUM_PAGES;
        page_base = AW'(page_int * ROW);
        start_now = SW'(col_i) + SW'(off_q);
        limit     = spare_off_i ? SW'(PAGE_BYTES) : SW'(ROW);
        avail_now = (start_now < SW'(ROW)) ? (SW'(ROW) - start_now) : '0;
        prog_n    = (SW'(buf_count) < prog_avail_q) ? SW'(buf_count) : prog_avail_q;
        go        = 1'b0;
        go_erase  = 1'b0;
        go_base   = '0;
        go_cnt    = '0;
        if (accept) begin
            case (op)
                OP_PROG_GO: if (collecting_q && wp_n_i && prog_ok_q) begin
                    go      = 1'b1;
                    go_base = prog_base_q;
                    go_cnt  = CW'(prog_n);
                end
                OP_ERASE: if (wp_n_i && blk_int < NUM_PAGES) begin
                    go       = 1'b1;
                    go_erase = 1'b1;
                    go_base  = AW'(blk_int * ROW);
                    go_cnt   = CW'(ERASE_N);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q        <= '0;
            rd_ptr       <= '0;
            rd_left      <= '0;
            collecting_q <= 1'b0;
            prog_ok_q    <= 1'b0;
            prog_base_q  <= '0;
            prog_avail_q <= '0;
        end else begin
            if (accept) begin
                collecting_q <= (op == OP_PROG_BEGIN);
                case (op)
                    OP_OFFSET: off_q <= start_off_i;
                    OP_LOAD: begin
                        off_q <= '0;
                        if (page_ok && start_now < limit) begin
                            rd_ptr  <= page_base + AW'(start_now);
                            rd_left <= limit - start_now;
                        end else begin
                            rd_left <= '0;
                        end
                    end
                    OP_PROG_BEGIN: begin
                        off_q        <= '0;
                        prog_ok_q    <= page_ok;
                        prog_base_q  <= page_base + AW'(start_now);
                        prog_avail_q <= avail_now;
                    end
                    default: ;
                endcase
            end
            if (!(accept && op == OP_LOAD) && !busy && rd_en_i && rd_left != '0) begin
                rd_ptr  <= rd_ptr + 1'b1;
                rd_left <= rd_left - 1'b1;
            end
        end
    end

    nand_pa_pgbuf #(.ROW(ROW), .IW(COL_W), .BCW(BCW)) u_pgbuf (
        .clk   (clk),
        .rst   (rst),
        .clear (accept && op == OP_PROG_BEGIN),
        .wr    (din_valid_i && collecting_q && !busy),
        .din   (din_i),
        .ridx  (COL_W'(idx)),
        .rdata (buf_rdata),
        .count (buf_count)
    );

    nand_pa_seq #(.AW(AW), .CW(CW), .HOLD(BUSY_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .go_erase (go_erase),
        .go_base  (go_base),
        .go_cnt   (go_cnt),
        .busy_o   (busy),
        .we_o     (we),
        .erase_o  (erase),
        .waddr_o  (waddr),
        .idx_o    (idx)
    );

    nand_pa_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .erase (erase),
        .waddr (waddr),
        .wdata (buf_rdata),
        .raddr (rd_ptr),
        .rdata (arr_rdata)
    );

    assign busy_o     = busy;
    assign rd_valid_o = (rd_left != '0);
    assign rd_data_o  = (rd_left != '0) ? arr_rdata : 8'h00;
endmodule

// File: rtl/nand_pa_checker.sv
module nand_pa_checker (
    input logic clk,
    input logic rst,
    input logic cmd_valid_i,
    input logic rd_en_i,
    input logic wp_n_i,
    input logic rd_valid_o,
    input logic busy_o
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy_o && !rd_valid_o)); // R1

    AST_STREAM_STARTS_ON_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid_o) |-> $past(cmd_valid_i)); // R2

    AST_STREAM_ENDS_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid_o) |-> ($past(rd_en_i) || $past(cmd_valid_i))); // R2

    AST_BUSY_NEEDS_WP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(wp_n_i)); // R7

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(cmd_valid_i)); // R10

    AST_BUSY_FREEZES_READ: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_valid_o)); // R10
endmodule

bind nand_page_array nand_pa_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .rd_en_i     (rd_en_i),
    .wp_n_i      (wp_n_i),
    .rd_valid_o  (rd_valid_o),
    .busy_o      (busy_o)
);

// File: tb/nand_page_array_tb.sv
module nand_page_array_tb;
    localparam int PB    = 256;
    localparam int NP    = 8;
    localparam int ES    = 2;
    localparam int PAW   = 4;
    localparam int HOLD  = 3;
    localparam int ROW   = PB + PB / 32;
    localparam int CLW   = $clog2(ROW);
    localparam int DEPTH = NP * ROW;
    localparam int BLK   = 1 << ES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [PAW-1:0] page = '0;
    logic [CLW-1:0] col = '0, soff = '0;
    logic din_valid = 1'b0;
    logic [7:0] din = '0;
    logic rd_en = 1'b0, wp_n = 1'b1, spare_off = 1'b0;
    logic [7:0] rd_data;
    logic rd_valid, busy;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] pdat [300];

    always #2.5 clk = ~clk;

    nand_page_array #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .ERASE_SHIFT(ES),
                      .PAGE_AW(PAW), .BUSY_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .page_i(page), .col_i(col), .start_off_i(soff), .din_valid_i(din_valid),
        .din_i(din), .rd_en_i(rd_en), .wp_n_i(wp_n), .spare_off_i(spare_off),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .busy_o(busy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input int op, input int pg, input int c, input int o);
        cmd_valid = 1'b1; cmd_op = 3'(op); page = PAW'(pg); col = CLW'(c); soff = CLW'(o);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic stream(input string req, input int pg, input int start, input int len);
        for (int i = 0; i < len; i++) begin
            chk(rd_valid === 1'b1 && rd_data === model[pg*ROW+start+i], req,
                int'(rd_data), int'(model[pg*ROW+start+i]));
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk(rd_valid === 1'b0, req, int'(rd_valid), 0);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            din_valid = 1'b1; din = pdat[i];
            @(negedge clk);
        end
        din_valid = 1'b0;
    endtask

    task automatic model_prog(input int pg, input int start, input int n);
        for (int i = 0; i < n && i < ROW; i++)
            if (start + i < ROW) model[pg*ROW+start+i] = model[pg*ROW+start+i] & pdat[i];
    endtask

    task automatic model_erase(input int pg);
        int b;
        b = (pg / BLK) * BLK;
        for (int i = b * ROW; i < (b + BLK) * ROW; i++) model[i] = 8'hFF;
    endtask

    task automatic full_read(input string req, input int pg);
        do_cmd(1, pg, 0, 0);
        stream(req, pg, 0, spare_off ? PB : ROW);
    endtask

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && rd_valid === 1'b0, "R1", int'({busy, rd_valid}), 0);
        for (int p = 0; p < NP; p++) full_read("R1", p);

        // R5/R6/R10: page 1 gets 270 bytes of F0, only ROW collected
        for (int i = 0; i < 300; i++) pdat[i] = 8'hF0;
        do_cmd(2, 1, 0, 0); send_bytes(270); do_cmd(3, 0, 0, 0);
        busy_len(n); chk(n == ROW + HOLD, "R10", n, ROW + HOLD);
        model_prog(1, 0, 270);
        for (int i = 0; i < 300; i++) pdat[i] = 8'h0F;
        do_cmd(2, 1, 0, 0); send_bytes(ROW); do_cmd(3, 0, 0, 0);
        busy_len(n); chk(n == ROW + HOLD, "R6", n, ROW + HOLD);
        model_prog(1, 0, ROW);
        chk(model[ROW] == 8'h00, "R5", int'(model[ROW]), 0);
        full_read("R5", 1);

        // R4/R5: offset 128 + column 16 on page 2, arithmetic pattern
        for (int i = 0; i < 300; i++) pdat[i] = 8'((i * 7 + 3) ^ 8'h5A);
        do_cmd(0, 0, 0, 128); do_cmd(2, 2, 16, 0); send_bytes(100); do_cmd(3, 0, 0, 0);
        busy_len(n); chk(n == 100 + HOLD, "R4", n, 100 + HOLD);
        model_prog(2, 144, 100);
        full_read("R5", 2);

        // R3: spare hidden
        spare_off = 1'b1;
        do_cmd(1, 2, 144, 0); stream("R3", 2, 144, PB - 144);
        full_read("R3", 1);
        spare_off = 1'b0;

        // R4: offset consumed by one load, then cleared
        do_cmd(0, 0, 0, PB); do_cmd(1, 1, 0, 0); stream("R4", 1, PB, ROW - PB);
        do_cmd(1, 1, 0, 0); stream("R4", 1, 0, ROW);

        // R6: start near end of row, only in-row bytes written
        for (int i = 0; i < 300; i++) pdat[i] = 8'(i * 3);
        do_cmd(2, 3, ROW - 4, 0); send_bytes(10); do_cmd(3, 0, 0, 0);
        busy_len(n); chk(n == 4 + HOLD, "R6", n, 4 + HOLD);
        model_prog(3, ROW - 4, 10);
        full_read("R6", 3); full_read("R6", 4);

        // R7: write protect blocks program and erase
        wp_n = 1'b0;
        for (int i = 0; i < 300; i++) pdat[i] = 8'h00;
        do_cmd(2, 3, 0, 0); send_bytes(ROW); do_cmd(3, 0, 0, 0);
        chk(busy === 1'b0, "R7", int'(busy), 0);
        do_cmd(4, 1, 0, 0);
        chk(busy === 1'b0, "R7", int'(busy), 0);
        wp_n = 1'b1;
        full_read("R7", 3); full_read("R7", 1);

        // R8: out-of-range page and block
        do_cmd(2, 9, 0, 0); send_bytes(ROW); do_cmd(3, 0, 0, 0);
        chk(busy === 1'b0, "R8", int'(busy), 0);
        do_cmd(4, 12, 0, 0);
        chk(busy === 1'b0, "R8", int'(busy), 0);
        do_cmd(1, 9, 0, 0);
        chk(rd_valid === 1'b0, "R8", int'(rd_valid), 0);
        for (int p = 0; p < NP; p++) full_read("R8", p);

        // R9/R10: fill pages 4 and 7, erase via page 6, load during busy ignored
        for (int i = 0; i < 300; i++) pdat[i] = 8'(i);
        do_cmd(2, 4, 0, 0); send_bytes(ROW); do_cmd(3, 0, 0, 0); busy_len(n);
        model_prog(4, 0, ROW);
        do_cmd(2, 7, 0, 0); send_bytes(ROW); do_cmd(3, 0, 0, 0); busy_len(n);
        model_prog(7, 0, ROW);
        full_read("R9", 7);
        do_cmd(4, 6, 0, 0);
        chk(busy === 1'b1, "R10", int'(busy), 1);
        do_cmd(1, 1, 0, 0);
        busy_len(n); n = n + 1;
        chk(n == BLK * ROW + HOLD, "R10", n, BLK * ROW + HOLD);
        chk(rd_valid === 1'b0, "R10", int'(rd_valid), 0);
        model_erase(6);
        for (int p = 0; p < NP; p++) full_read("R9", p);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule